// File: doc/BRIEF.md
# Fixed-Priority Three-Source Interrupt Arbiter

This block gathers three interrupt requests for a small processor core: two external pins and a timer overflow flag. It chooses one of them and presents a single request line and the vector address the core should jump to. Each external pin has a mode bit. In edge mode a falling edge on the synchronised pin sets a sticky pending flag. In level mode the request simply follows the pin while it is held low. The timer request is taken as a level from the timer. A single global enable and one enable per source mask the requests before arbitration.

There is one priority level only. Conflicts are settled by a fixed order: external pin 0 first, then the timer, then external pin 1. When the core accepts a vector with the acknowledge strobe, the block records that a service is in progress, clears the winner's edge flag and, for the timer, pulses a clear strobe back to the timer. No new request is presented until a return strobe arrives, so a pending source never preempts a running handler. A wake output signals an enabled request at any time, so that an idle core can resume.

Top module: `fpirq_ctrl`

## Requirements
- R1: When more than one enabled request is present, the winner is external pin 0 first, then the timer, then external pin 1.
- R2: `irq_vec` reads 0x003 for pin 0, 0x00B for the timer and 0x013 for pin 1 while `irq_req` is high, and 0x000 whenever `irq_req` is low.
- R3: With a pin's mode bit at 1 (edge mode), a high-to-low transition of the synchronised pin sets its pending flag (`ext0_pend` / `ext1_pend`). The flag and the request stay set after the pin returns high, and a pin that stays low sets the flag only once.
- R4: With a pin's mode bit at 0 (level mode), the request is present only while the synchronised pin is low and is not remembered once the pin rises. The pending flag reads 0 in this mode.
- R5: An acknowledge while `irq_req` is high sets `irq_busy` on the next cycle and clears the winning pin's pending flag. If the timer wins, `tmr_ack` is high during that acknowledge cycle and at no other time.
- R6: While `irq_busy` is high, `irq_req` stays low whatever arrives. A `reti` pulse clears `irq_busy`, after which the highest pending request is presented.
- R7: `glb_en` low removes every request. A source whose own enable is low takes no part in arbitration, so a lower-order source can win.
- R8: `wake` is high whenever any request survives masking, including while `irq_busy` is high.
- R9: An acknowledge with no request present, and a `reti` with no service in progress, change nothing.
- R10: After reset `irq_req`, `irq_busy`, both pending flags and `wake` are low and `irq_vec` is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext0_pin | input | 1 | External interrupt pin 0, active low, asynchronous |
| ext1_pin | input | 1 | External interrupt pin 1, active low, asynchronous |
| tmr_ovf | input | 1 | Timer overflow flag (level) |
| glb_en | input | 1 | Global interrupt enable |
| ext0_en | input | 1 | Enable for pin 0 |
| tmr_en | input | 1 | Enable for the timer |
| ext1_en | input | 1 | Enable for pin 1 |
| ext0_edge_mode | input | 1 | 1: pin 0 edge mode, 0: level mode |
| ext1_edge_mode | input | 1 | 1: pin 1 edge mode, 0: level mode |
| vec_ack | input | 1 | Core accepts the presented vector |
| reti | input | 1 | Core returns from the handler |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | VEC_W | Vector address of the winner |
| irq_busy | output | 1 | Service in progress |
| ext0_pend | output | 1 | Edge pending flag of pin 0 |
| ext1_pend | output | 1 | Edge pending flag of pin 1 |
| tmr_ack | output | 1 | Clear strobe for the timer flag |
| wake | output | 1 | Enabled request present (ends idle) |

## Verification
A stuck or wrongly cleared pending flag shows at `ext0_pend`/`ext1_pend` one cycle after the acknowledge or the synchronised edge. It also shows as a wrong vector in the following request. A lost or stuck in-service bit shows at once: either `irq_req` rises while a handler runs, or it fails to return one cycle after `reti`. A wrong priority or vector encoding is visible in the same cycle on `irq_vec` when several requests are set up at the same time. The pin paths add the synchroniser latency, so the bench samples them a fixed number of cycles after each edge.

// File: rtl/fpirq_pkg.sv
package fpirq_pkg;
   localparam int unsigned NUM_SRC = 3;
   // arbitration order equals index order: lowest index wins
   localparam int unsigned IDX_EXT0 = 0;
   localparam int unsigned IDX_TMR  = 1;
   localparam int unsigned IDX_EXT1 = 2;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_EXT0 = 2'd1,
      SRC_TMR  = 2'd2,
      SRC_EXT1 = 2'd3
   } fpirq_src_e;

   function automatic fpirq_src_e idx_to_src(input int unsigned idx);
      case (idx)
         IDX_EXT0: return SRC_EXT0;
         IDX_TMR:  return SRC_TMR;
         IDX_EXT1: return SRC_EXT1;
         default:  return SRC_NONE;
      endcase
   endfunction
endpackage

// File: rtl/fpirq_sync.sv
module fpirq_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fpirq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= RST_VAL;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fpirq_pin.sv
module fpirq_pin #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          ACTIVE_LOW  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic edge_mode,
   input  logic clr,
   output logic pend,
   output logic req
);
   localparam bit IDLE_LVL = ACTIVE_LOW ? 1'b1 : 1'b0;

   logic pin_s;
   logic pin_prev;
   logic active;
   logic trans;

   fpirq_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IDLE_LVL)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin),
      .q     (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev <= IDLE_LVL;
      else        pin_prev <= pin_s;
   end

   if (ACTIVE_LOW) begin : g_low
      assign active = ~pin_s;
      assign trans  = pin_prev & ~pin_s;
   end else begin : g_high
      assign active = pin_s;
      assign trans  = ~pin_prev & pin_s;
   end

   // edge flag: a fresh edge wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend <= 1'b0;
      else if (!edge_mode) pend <= 1'b0;
      else if (trans)      pend <= 1'b1;
      else if (clr)        pend <= 1'b0;
   end

   assign req = edge_mode ? pend : active;
endmodule

// File: rtl/fpirq_arb.sv
module fpirq_arb
   import fpirq_pkg::*;
#(
   parameter int unsigned VEC_W    = 11,
   parameter int unsigned VEC_EXT0 = 11'h003,
   parameter int unsigned VEC_TMR  = 11'h00B,
   parameter int unsigned VEC_EXT1 = 11'h013,
   parameter int unsigned VEC_IDLE = 11'h000
) (
   input  logic [NUM_SRC-1:0] req,
   input  logic               block,
   output logic               irq_req,
   output logic [VEC_W-1:0]   irq_vec,
   output fpirq_src_e         grant
);
   localparam logic [VEC_W-1:0] VEC_TAB [NUM_SRC] = '{
      VEC_EXT0[VEC_W-1:0], VEC_TMR[VEC_W-1:0], VEC_EXT1[VEC_W-1:0]
   };

   fpirq_src_e win;

   always_comb begin
      win = SRC_NONE;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req[i]) win = idx_to_src(i);
      end
   end

   assign irq_req = (win != SRC_NONE) && !block;
   assign grant   = irq_req ? win : SRC_NONE;

   always_comb begin
      irq_vec = VEC_IDLE[VEC_W-1:0];
      case (grant)
         SRC_EXT0: irq_vec = VEC_TAB[IDX_EXT0];
         SRC_TMR:  irq_vec = VEC_TAB[IDX_TMR];
         SRC_EXT1: irq_vec = VEC_TAB[IDX_EXT1];
         default:  irq_vec = VEC_IDLE[VEC_W-1:0];
      endcase
   end
endmodule

// File: rtl/fpirq_ctrl.sv
module fpirq_ctrl
   import fpirq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          ACTIVE_LOW  = 1'b1,
   parameter int unsigned VEC_W       = 11,
   parameter int unsigned VEC_EXT0    = 11'h003,
   parameter int unsigned VEC_TMR     = 11'h00B,
   parameter int unsigned VEC_EXT1    = 11'h013,
   parameter int unsigned VEC_IDLE    = 11'h000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext0_pin,
   input  logic             ext1_pin,
   input  logic             tmr_ovf,
   input  logic             glb_en,
   input  logic             ext0_en,
   input  logic             tmr_en,
   input  logic             ext1_en,
   input  logic             ext0_edge_mode,
   input  logic             ext1_edge_mode,
   input  logic             vec_ack,
   input  logic             reti,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec,
   output logic             irq_busy,
   output logic             ext0_pend,
   output logic             ext1_pend,
   output logic             tmr_ack,
   output logic             wake
);
   localparam int unsigned VEC_LIM = 1 << VEC_W;

   if (VEC_W < 5 || VEC_W > 16) begin : g_bad_w
      $error("fpirq_ctrl: VEC_W out of range");
   end
   if (VEC_EXT0 >= VEC_LIM || VEC_TMR >= VEC_LIM ||
       VEC_EXT1 >= VEC_LIM || VEC_IDLE >= VEC_LIM) begin : g_bad_vec
      $error("fpirq_ctrl: vector does not fit VEC_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fpirq_ctrl: SYNC_STAGES must be at least 2");
   end

   localparam int unsigned NUM_PIN = 2;

   logic [NUM_PIN-1:0] pin_in;
   logic [NUM_PIN-1:0] pin_mode;
   logic [NUM_PIN-1:0] pin_clr;
   logic [NUM_PIN-1:0] pin_pend;
   logic [NUM_PIN-1:0] pin_req;
   logic [NUM_SRC-1:0] raw_req;
   logic [NUM_SRC-1:0] src_en;
   logic [NUM_SRC-1:0] masked;
   fpirq_src_e         grant;
   logic               take;
   logic               busy_q;

   assign pin_in   = {ext1_pin, ext0_pin};
   assign pin_mode = {ext1_edge_mode, ext0_edge_mode};

   // the acknowledge is taken only while a request is presented
   assign take = vec_ack && irq_req;

   assign pin_clr[0] = take && (grant == SRC_EXT0);
   assign pin_clr[1] = take && (grant == SRC_EXT1);

   for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      fpirq_pin #(
         .SYNC_STAGES (SYNC_STAGES),
         .ACTIVE_LOW  (ACTIVE_LOW)
      ) u_pin (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin       (pin_in[p]),
         .edge_mode (pin_mode[p]),
         .clr       (pin_clr[p]),
         .pend      (pin_pend[p]),
         .req       (pin_req[p])
      );
   end

   assign raw_req[IDX_EXT0] = pin_req[0];
   assign raw_req[IDX_TMR]  = tmr_ovf;
   assign raw_req[IDX_EXT1] = pin_req[1];

   assign src_en[IDX_EXT0] = ext0_en;
   assign src_en[IDX_TMR]  = tmr_en;
   assign src_en[IDX_EXT1] = ext1_en;

   assign masked = raw_req & src_en & {NUM_SRC{glb_en}};

   fpirq_arb #(
      .VEC_W    (VEC_W),
      .VEC_EXT0 (VEC_EXT0),
      .VEC_TMR  (VEC_TMR),
      .VEC_EXT1 (VEC_EXT1),
      .VEC_IDLE (VEC_IDLE)
   ) u_arb (
      .req     (masked),
      .block   (busy_q),
      .irq_req (irq_req),
      .irq_vec (irq_vec),
      .grant   (grant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_q <= 1'b0;
      else if (take)   busy_q <= 1'b1;
      else if (reti)   busy_q <= 1'b0;
   end

   assign irq_busy  = busy_q;
   assign ext0_pend = pin_pend[0];
   assign ext1_pend = pin_pend[1];
   assign tmr_ack   = take && (grant == SRC_TMR);
   assign wake      = |masked;
endmodule

// File: rtl/fpirq_chk.sv
module fpirq_chk #(
   parameter int unsigned VEC_W    = 11,
   parameter int unsigned VEC_EXT0 = 11'h003,
   parameter int unsigned VEC_TMR  = 11'h00B,
   parameter int unsigned VEC_IDLE = 11'h000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             glb_en,
   input logic             ext0_en,
   input logic             ext0_edge_mode,
   input logic             ext1_edge_mode,
   input logic             vec_ack,
   input logic             reti,
   input logic             irq_req,
   input logic [VEC_W-1:0] irq_vec,
   input logic             irq_busy,
   input logic             ext0_pend,
   input logic             ext1_pend,
   input logic             tmr_ack,
   input logic             wake
);
   p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_busy |-> !irq_req);

   p_reti_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_busy && reti) |=> !irq_busy);

   p_ack_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && vec_ack) |=> irq_busy);

   p_tmr_ack_only_on_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ack |-> (irq_req && vec_ack && irq_vec == VEC_TMR[VEC_W-1:0]));

   p_idle_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_vec == VEC_IDLE[VEC_W-1:0]));

   p_ext0_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && glb_en && ext0_en && ext0_edge_mode && ext0_pend)
      |-> (irq_vec == VEC_EXT0[VEC_W-1:0]));

   p_global_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> (!irq_req && !wake));

   p_req_implies_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> wake);

   p_level_no_flag0_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ext0_edge_mode |=> !ext0_pend);

   p_level_no_flag1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ext1_edge_mode |=> !ext1_pend);

   p_idle_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_busy && !(irq_req && vec_ack)) |=> !irq_busy);
endmodule

bind fpirq_ctrl fpirq_chk #(
   .VEC_W    (VEC_W),
   .VEC_EXT0 (VEC_EXT0),
   .VEC_TMR  (VEC_TMR),
   .VEC_IDLE (VEC_IDLE)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .glb_en         (glb_en),
   .ext0_en        (ext0_en),
   .ext0_edge_mode (ext0_edge_mode),
   .ext1_edge_mode (ext1_edge_mode),
   .vec_ack        (vec_ack),
   .reti           (reti),
   .irq_req        (irq_req),
   .irq_vec        (irq_vec),
   .irq_busy       (irq_busy),
   .ext0_pend      (ext0_pend),
   .ext1_pend      (ext1_pend),
   .tmr_ack        (tmr_ack),
   .wake           (wake)
);

// File: tb/sim_fpirq_ctrl.sv
module sim_fpirq_ctrl;
   localparam int VW = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext0_pin = 1'b1, ext1_pin = 1'b1, tmr_ovf = 1'b0;
   logic glb_en = 1'b1, ext0_en = 1'b1, tmr_en = 1'b1, ext1_en = 1'b1;
   logic ext0_edge_mode = 1'b1, ext1_edge_mode = 1'b0;
   logic vec_ack = 1'b0, reti = 1'b0;
   logic irq_req, irq_busy, ext0_pend, ext1_pend, tmr_ack, wake;
   logic [VW-1:0] irq_vec;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fpirq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ext0_pin(ext0_pin), .ext1_pin(ext1_pin),
      .tmr_ovf(tmr_ovf), .glb_en(glb_en), .ext0_en(ext0_en), .tmr_en(tmr_en),
      .ext1_en(ext1_en), .ext0_edge_mode(ext0_edge_mode),
      .ext1_edge_mode(ext1_edge_mode), .vec_ack(vec_ack), .reti(reti),
      .irq_req(irq_req), .irq_vec(irq_vec), .irq_busy(irq_busy),
      .ext0_pend(ext0_pend), .ext1_pend(ext1_pend), .tmr_ack(tmr_ack),
      .wake(wake)
   );

   task automatic check(input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // acknowledge strobe lasting one clock edge; tmr_ack checked inside it
   task automatic do_ack(input bit exp_tmr_ack);
      vec_ack = 1'b1;
      #1;
      check("R5", "tmr_ack during ack", tmr_ack, exp_tmr_ack);
      tick(1);
      vec_ack = 1'b0;
   endtask

   task automatic do_reti();
      reti = 1'b1;
      tick(1);
      reti = 1'b0;
   endtask

   task automatic pulse0(input int low_cycles);
      ext0_pin = 1'b0;
      tick(low_cycles);
      ext0_pin = 1'b1;
   endtask

   task automatic t_reset();
      check("R10", "irq_req", irq_req, 0);
      check("R10", "irq_vec", irq_vec, 'h000);
      check("R10", "irq_busy", irq_busy, 0);
      check("R10", "ext0_pend", ext0_pend, 0);
      check("R10", "ext1_pend", ext1_pend, 0);
      check("R10", "wake", wake, 0);
   endtask

   task automatic t_edge0();
      ext0_edge_mode = 1'b1;
      pulse0(2);
      tick(4);
      check("R3", "pend after edge", ext0_pend, 1);
      check("R3", "req held after pin high", irq_req, 1);
      check("R2", "vec ext0", irq_vec, 'h003);
      do_ack(1'b0);
      check("R5", "busy after ack", irq_busy, 1);
      check("R5", "pend cleared by ack", ext0_pend, 0);
      check("R6", "req low while busy", irq_req, 0);
      do_reti();
      check("R6", "busy cleared by reti", irq_busy, 0);
      check("R2", "vec idle", irq_vec, 'h000);
      // pin held low: only one flag
      ext0_pin = 1'b0;
      tick(5);
      do_ack(1'b0);
      do_reti();
      tick(4);
      check("R3", "no new flag while pin stays low", ext0_pend, 0);
      ext0_pin = 1'b1;
      tick(4);
   endtask

   task automatic t_level();
      ext1_edge_mode = 1'b0;
      ext1_pin = 1'b0;
      tick(4);
      check("R4", "level req", irq_req, 1);
      check("R2", "vec ext1", irq_vec, 'h013);
      check("R4", "no flag in level mode", ext1_pend, 0);
      ext1_pin = 1'b1;
      tick(4);
      check("R4", "level not latched", irq_req, 0);
      ext0_edge_mode = 1'b0;
      pulse0(3);
      tick(4);
      check("R4", "ext0 level not latched", irq_req, 0);
      check("R4", "ext0 flag stays 0", ext0_pend, 0);
      ext0_edge_mode = 1'b1;
   endtask

   task automatic t_priority();
      tmr_ovf = 1'b1;
      ext1_pin = 1'b0;
      pulse0(2);
      tick(4);
      check("R1", "ext0 beats all", irq_vec, 'h003);
      do_ack(1'b0);
      do_reti();
      check("R1", "timer next", irq_vec, 'h00B);
      do_ack(1'b1);
      tmr_ovf = 1'b0;
      check("R5", "busy after timer ack", irq_busy, 1);
      check("R5", "tmr_ack idle after", tmr_ack, 0);
      do_reti();
      check("R1", "ext1 last", irq_vec, 'h013);
      do_ack(1'b0);
      ext1_pin = 1'b1;
      do_reti();
      tick(4);
      check("R1", "nothing left", irq_req, 0);
   endtask

   task automatic t_mask();
      ext1_pin = 1'b0;
      pulse0(2);
      tick(4);
      ext0_en = 1'b0;
      #1;
      check("R7", "masked ext0 loses", irq_vec, 'h013);
      glb_en = 1'b0;
      #1;
      check("R7", "global off req", irq_req, 0);
      check("R8", "global off wake", wake, 0);
      glb_en = 1'b1;
      ext0_en = 1'b1;
      #1;
      check("R7", "ext0 back", irq_vec, 'h003);
      tick(1);
      do_ack(1'b0);
      do_reti();
      ext1_pin = 1'b1;
      tick(4);
      check("R7", "clean", irq_req, 0);
   endtask

   task automatic t_no_preempt();
      ext1_pin = 1'b0;
      tick(4);
      do_ack(1'b0);
      ext1_pin = 1'b1;
      pulse0(2);
      tick(4);
      check("R6", "no preempt", irq_req, 0);
      check("R3", "flag pending while busy", ext0_pend, 1);
      check("R8", "wake while busy", wake, 1);
      do_reti();
      check("R6", "pending after reti", irq_vec, 'h003);
      do_ack(1'b0);
      do_reti();
   endtask

   task automatic t_ignored();
      tick(2);
      vec_ack = 1'b1;
      #1;
      check("R9", "tmr_ack with no req", tmr_ack, 0);
      tick(1);
      vec_ack = 1'b0;
      check("R9", "busy after stray ack", irq_busy, 0);
      do_reti();
      check("R9", "busy after stray reti", irq_busy, 0);
      check("R9", "req after stray reti", irq_req, 0);
   endtask

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_edge0();
      t_level();
      t_priority();
      t_mask();
      t_no_preempt();
      t_ignored();
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule